// File: doc/BRIEF.md
# Nine-Bit Capable Serial Receiver

This block recovers characters from one asynchronous serial line. It counts a one-cycle tick that arrives sixteen times per bit period from an external rate generator, so it holds no divider of its own. It confirms each falling edge as a start bit and votes each bit from three samples taken around the middle of the bit. It then hands the character to the surrounding logic with a one-cycle ready strobe. The character carries 7, 8 or 9 data bits, bit 0 first. The 7- and 8-bit shapes may carry a parity bit of odd or even sense. Every shape ends with one or two stop bits.

In the 9-bit shape the low eight bits land in the byte output and the top bit is presented on its own output. An attention filter can then drop every character whose top bit is 0, so a node on a shared line only wakes for address characters. A loopback control takes the line from the local transmitter's serial output in place of the device pin. While loopback is set, the character shape is forced to 9 data bits with no parity, and the stop-bit count still follows its control input.

The character shape is sampled when a start edge is seen and held for the whole character. The outputs keep their values until the next accepted character.

Top module: `serial_rx9`

## Requirements
- R1: After a synchronous reset, rx_ready, rx_data, rx_bit9, parity_err and frame_err are all 0.
- R2: With data_len = 1 (8 data bits), a character sent bit 0 first appears on rx_data. It comes with a one-cycle rx_ready pulse, and rx_bit9 is 0.
- R3: With data_len = 0 (7 data bits), rx_data[6:0] holds the character and rx_data[7] and rx_bit9 are 0. The next bit after the seventh data bit is treated as parity or stop.
- R4: With data_len = 2 or 3 (9 data bits), rx_data takes data bits 0 to 7 and rx_bit9 takes data bit 8. No parity bit is expected, parity_en has no effect, and parity_err is 0.
- R5: In the 7- and 8-bit shapes with parity_en = 1, one parity bit follows the last data bit. parity_odd = 1 asks for an odd count of ones over the data and parity bits, and parity_odd = 0 asks for an even count. A mismatch gives parity_err = 1 with that character.
- R6: two_stop = 1 expects two stop bits and two_stop = 0 expects one. If the vote at any stop bit is low, frame_err is 1 with that character, and the character is still delivered.
- R7: A low level that lasts less than half a bit period after the line was idle is rejected as a false start. No character is produced.
- R8: Each bit is the 2-of-3 majority of the tick samples numbered 7, 8 and 9 of that bit, where the start-detection tick is sample 0. One disturbed tick sample in the middle of a bit does not change the received value.
- R9: With loop_en = 1 the receiver takes its line from loop_tx and ignores rx_pin. It uses 9 data bits with no parity whatever data_len and parity_en say, and two_stop still picks the stop count.
- R10: With attn_en = 1 in the 9-bit shape, a character whose ninth bit is 0 is dropped: no rx_ready pulse, and all outputs keep their values. A character whose ninth bit is 1 is delivered.
- R11: rx_data, rx_bit9, parity_err and frame_err change only in the cycle in which rx_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle strobe, 16 per bit period |
| rx_pin | input | 1 | Serial line from the device pin, idle high |
| loop_tx | input | 1 | Local transmitter serial output, used in loopback |
| loop_en | input | 1 | 1 selects loop_tx and forces 9 bits, no parity |
| data_len | input | 2 | 0: 7 bits, 1: 8 bits, 2 or 3: 9 bits |
| parity_en | input | 1 | Parity bit present (7- and 8-bit shapes only) |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| two_stop | input | 1 | 1: two stop bits, 0: one |
| attn_en | input | 1 | Drop 9-bit characters whose ninth bit is 0 |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Ninth data bit of the last character |
| rx_ready | output | 1 | One-cycle strobe for a delivered character |
| parity_err | output | 1 | Parity mismatch in the last character |
| frame_err | output | 1 | Low stop bit in the last character |

## Verification
The assertions read the shape controls at the cycle of rx_ready. They therefore assume that data_len, parity_en, loop_en and attn_en hold still from the start edge to delivery, and that tick16 never lasts more than one cycle. The stimulus changes configuration only while the line has been idle for several ticks, and it generates the tick as a single-cycle strobe every fourth clock. Disturbed samples and short false starts are placed on whole clock periods so that at most one tick sample of a bit is hit.

// File: rtl/serial_rx9_pkg.sv
package serial_rx9_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_on;
    logic       par_odd;
    logic       two_stop;
    logic       attn;
  } rx_cfg_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_select.sv
module rx_line_select #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic loop_line,
  input  logic loop_en,
  output logic line_o
);

  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;

  assign raw = loop_en ? loop_line : pin;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign line_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/rx_majority.sv
module rx_majority
  import serial_rx9_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  output logic vote
);

  logic [1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst)       hist_q <= 2'b11;
    else if (tick) hist_q <= {hist_q[0], line};
  end

  assign vote = maj3(hist_q[1], hist_q[0], line);

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import serial_rx9_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic       vote,
  input  rx_cfg_t    cfg_in,
  output logic [7:0] data_o,
  output logic       bit9_o,
  output logic       ready_o,
  output logic       perr_o,
  output logic       ferr_o
);

  localparam int              CNT_W     = $clog2(OVS);
  localparam int              SH_W      = 9;
  localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(OVS - 1);

  rx_state_e        st_q;
  rx_cfg_t          cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       idx_q;
  logic [SH_W-1:0]  sh_q;
  logic             acc_q;
  logic             fe_q;

  logic at_sample, at_end, last_data, last_stop, drop;

  assign at_sample = (cnt_q == SAMPLE_AT);
  assign at_end    = (cnt_q == LAST_CNT);
  assign last_data = (idx_q == cfg_q.nbits - 4'd1);
  assign last_stop = (idx_q == {3'b000, cfg_q.two_stop});
  assign drop      = cfg_q.attn && (cfg_q.nbits == 4'd9) && !sh_q[8];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      fe_q    <= 1'b0;
      data_o  <= '0;
      bit9_o  <= 1'b0;
      ready_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      if (tick) begin
        cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        case (st_q)
          ST_IDLE: begin
            if (!line) begin
              st_q  <= ST_START;
              cnt_q <= CNT_W'(1);
              cfg_q <= cfg_in;
              sh_q  <= '0;
              acc_q <= 1'b0;
              fe_q  <= 1'b0;
              idx_q <= '0;
            end
          end
          ST_START: begin
            if (at_sample && vote) begin
              st_q <= ST_IDLE;
            end else if (at_end) begin
              st_q  <= ST_DATA;
              idx_q <= '0;
            end
          end
          ST_DATA: begin
            if (at_sample) begin
              for (int i = 0; i < SH_W; i++) begin
                if (idx_q == 4'(i)) sh_q[i] <= vote;
              end
              acc_q <= acc_q ^ vote;
            end
            if (at_end) begin
              if (last_data) begin
                st_q  <= cfg_q.par_on ? ST_PAR : ST_STOP;
                idx_q <= '0;
              end else begin
                idx_q <= idx_q + 4'd1;
              end
            end
          end
          ST_PAR: begin
            if (at_sample) acc_q <= acc_q ^ vote;
            if (at_end) begin
              st_q  <= ST_STOP;
              idx_q <= '0;
            end
          end
          ST_STOP: begin
            if (at_sample) begin
              if (last_stop) begin
                st_q <= ST_IDLE;
                if (!drop) begin
                  data_o  <= sh_q[7:0];
                  bit9_o  <= sh_q[8];
                  perr_o  <= cfg_q.par_on & (acc_q ^ cfg_q.par_odd);
                  ferr_o  <= fe_q | !vote;
                  ready_o <= 1'b1;
                end
              end else begin
                fe_q <= fe_q | !vote;
              end
            end
            if (at_end) idx_q <= idx_q + 4'd1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_rx9.sv
module serial_rx9
  import serial_rx9_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rx_pin,
  input  logic       loop_tx,
  input  logic       loop_en,
  input  logic [1:0] data_len,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       two_stop,
  input  logic       attn_en,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_ready,
  output logic       parity_err,
  output logic       frame_err
);

  logic    line;
  logic    vote;
  rx_cfg_t cfg;
  logic [3:0] nbits;

  always_comb begin
    if (loop_en)             nbits = 4'd9;
    else if (data_len == 2'd0) nbits = 4'd7;
    else if (data_len == 2'd1) nbits = 4'd8;
    else                     nbits = 4'd9;
    cfg.nbits    = nbits;
    cfg.par_on   = parity_en && (nbits != 4'd9);
    cfg.par_odd  = parity_odd;
    cfg.two_stop = two_stop;
    cfg.attn     = attn_en;
  end

  rx_line_select #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .pin       (rx_pin),
    .loop_line (loop_tx),
    .loop_en   (loop_en),
    .line_o    (line)
  );

  rx_majority u_maj (
    .clk  (clk),
    .rst  (rst),
    .tick (tick16),
    .line (line),
    .vote (vote)
  );

  rx_deframer #(.OVS(OVS)) u_dfr (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick16),
    .line    (line),
    .vote    (vote),
    .cfg_in  (cfg),
    .data_o  (rx_data),
    .bit9_o  (rx_bit9),
    .ready_o (rx_ready),
    .perr_o  (parity_err),
    .ferr_o  (frame_err)
  );

endmodule

// File: rtl/serial_rx9_chk.sv
module serial_rx9_chk (
  input logic       clk,
  input logic       rst,
  input logic       loop_en,
  input logic [1:0] data_len,
  input logic       attn_en,
  input logic [7:0] rx_data,
  input logic       rx_bit9,
  input logic       rx_ready,
  input logic       parity_err,
  input logic       frame_err
);

  logic nine;
  assign nine = loop_en || data_len[1];

  a_r2_ready_single: assert property (@(posedge clk) disable iff (rst)
    rx_ready |=> !rx_ready);

  a_r2_no_bit9_in_byte: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !loop_en && data_len == 2'd1) |-> !rx_bit9);

  a_r3_top_bits_clear: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !loop_en && data_len == 2'd0) |-> (!rx_data[7] && !rx_bit9));

  a_r4_no_parity_nine: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && nine) |-> !parity_err);

  a_r9_loop_no_parity: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && loop_en) |-> !parity_err);

  a_r10_attn_pass: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && attn_en && nine) |-> rx_bit9);

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_ready |-> ($stable(rx_data) && $stable(rx_bit9) &&
                   $stable(parity_err) && $stable(frame_err)));

endmodule

bind serial_rx9 serial_rx9_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .loop_en    (loop_en),
  .data_len   (data_len),
  .attn_en    (attn_en),
  .rx_data    (rx_data),
  .rx_bit9    (rx_bit9),
  .rx_ready   (rx_ready),
  .parity_err (parity_err),
  .frame_err  (frame_err)
);

// File: tb/serial_rx9_bench.sv
`timescale 1ns/1ps
module serial_rx9_bench;

  localparam int TPD  = 4;
  localparam int BITC = 16 * TPD;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16;
  logic       rx_pin = 1'b1;
  logic       loop_tx = 1'b1;
  logic       loop_en = 1'b0;
  logic [1:0] data_len = 2'd1;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       attn_en = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_ready, parity_err, frame_err;

  int  tests = 0;
  int  fails = 0;
  int  got_cnt = 0;
  bit  to_loop = 1'b0;
  bit  finished = 1'b0;
  int  tcnt = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) tcnt <= (tcnt == TPD - 1) ? 0 : tcnt + 1;
  assign tick16 = (tcnt == 0);

  serial_rx9 u_serial_rx9 (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_pin(rx_pin), .loop_tx(loop_tx),
    .loop_en(loop_en), .data_len(data_len), .parity_en(parity_en),
    .parity_odd(parity_odd), .two_stop(two_stop), .attn_en(attn_en),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ready(rx_ready),
    .parity_err(parity_err), .frame_err(frame_err)
  );

  always @(negedge clk) if (!rst && rx_ready) got_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input bit b);
    if (to_loop) loop_tx = b;
    else         rx_pin  = b;
  endtask

  task automatic send_bit(input bit b, input bit g);
    drive(b);
    if (g) begin
      wait_clks(BITC / 2);
      drive(~b);
      wait_clks(TPD);
      drive(b);
      wait_clks(BITC / 2 - TPD);
    end else begin
      wait_clks(BITC);
    end
  endtask

  task automatic send_frame(input logic [8:0] v, input int nb, input bit pen, input bit pbit,
                            input int nstop, input bit [1:0] bad, input logic [8:0] gmask);
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) send_bit(v[i], gmask[i]);
    if (pen) send_bit(pbit, 1'b0);
    for (int k = 0; k < nstop; k++) send_bit(!bad[k], 1'b0);
    drive(1'b1);
    wait_clks(2 * BITC);
  endtask

  function automatic bit par_bit(input logic [8:0] v, input int nb, input bit odd);
    bit x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= v[i];
    return x ^ odd;
  endfunction

  task automatic expect_char(input string tag, input int n0, input logic [7:0] ed,
                             input logic eb9, input logic ep, input logic ef);
    chk({tag, " count"}, got_cnt, n0 + 1);
    chk({tag, " data"}, rx_data, ed);
    chk({tag, " bit9"}, rx_bit9, eb9);
    chk({tag, " parity_err"}, parity_err, ep);
    chk({tag, " frame_err"}, frame_err, ef);
  endtask

  task automatic set_cfg(input logic [1:0] dl, input bit pe, input bit po, input bit ts, input bit at);
    data_len = dl; parity_en = pe; parity_odd = po; two_stop = ts; attn_en = at;
    wait_clks(8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [7:0] prev;
    void'($urandom(32'h5A17));
    wait_clks(6);
    rst = 1'b0;
    wait_clks(2);
    // R1 reset state
    chk("R1 ready", rx_ready, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 bit9", rx_bit9, 0);
    chk("R1 perr", parity_err, 0);
    chk("R1 ferr", frame_err, 0);

    // R2 plain 8-bit
    set_cfg(2'd1, 0, 0, 0, 0);
    n0 = got_cnt; send_frame(9'h0A5, 8, 0, 0, 1, 2'b00, 9'h0);
    expect_char("R2 8bit A5", n0, 8'hA5, 0, 0, 0);

    // R3 seven bits, bit 7 of source set but never sent
    set_cfg(2'd0, 0, 0, 0, 0);
    n0 = got_cnt; send_frame(9'h0D5, 7, 0, 0, 1, 2'b00, 9'h0);
    expect_char("R3 7bit", n0, 8'h55, 0, 0, 0);

    // R4 nine bits, parity_en ignored
    set_cfg(2'd2, 1, 1, 0, 0);
    n0 = got_cnt; send_frame(9'h13C, 9, 0, 0, 1, 2'b00, 9'h0);
    expect_char("R4 9bit hi", n0, 8'h3C, 1, 0, 0);
    set_cfg(2'd3, 1, 0, 0, 0);
    n0 = got_cnt; send_frame(9'h0C3, 9, 0, 0, 1, 2'b00, 9'h0);
    expect_char("R4 9bit lo", n0, 8'hC3, 0, 0, 0);

    // R5 parity
    set_cfg(2'd1, 1, 0, 0, 0);
    n0 = got_cnt; send_frame(9'h037, 8, 1, par_bit(9'h037, 8, 0), 1, 2'b00, 9'h0);
    expect_char("R5 even ok", n0, 8'h37, 0, 0, 0);
    n0 = got_cnt; send_frame(9'h037, 8, 1, !par_bit(9'h037, 8, 0), 1, 2'b00, 9'h0);
    expect_char("R5 even bad", n0, 8'h37, 0, 1, 0);
    set_cfg(2'd0, 1, 1, 0, 0);
    n0 = got_cnt; send_frame(9'h012, 7, 1, par_bit(9'h012, 7, 1), 1, 2'b00, 9'h0);
    expect_char("R5 odd ok", n0, 8'h12, 0, 0, 0);
    n0 = got_cnt; send_frame(9'h012, 7, 1, !par_bit(9'h012, 7, 1), 1, 2'b00, 9'h0);
    expect_char("R5 odd bad", n0, 8'h12, 0, 1, 0);

    // R6 stop bits
    set_cfg(2'd1, 0, 0, 1, 0);
    n0 = got_cnt; send_frame(9'h081, 8, 0, 0, 2, 2'b00, 9'h0);
    expect_char("R6 two ok", n0, 8'h81, 0, 0, 0);
    n0 = got_cnt; send_frame(9'h042, 8, 0, 0, 2, 2'b10, 9'h0);
    expect_char("R6 second low", n0, 8'h42, 0, 0, 1);
    set_cfg(2'd1, 0, 0, 0, 0);
    n0 = got_cnt; send_frame(9'h0F0, 8, 0, 0, 1, 2'b01, 9'h0);
    expect_char("R6 one low", n0, 8'hF0, 0, 0, 1);
    n0 = got_cnt; send_frame(9'h00F, 8, 0, 0, 1, 2'b00, 9'h0);
    expect_char("R6 clears", n0, 8'h0F, 0, 0, 0);

    // R7 short low pulse is a false start; R11 outputs held
    n0 = got_cnt; prev = rx_data;
    drive(1'b0); wait_clks(2 * TPD); drive(1'b1); wait_clks(20 * BITC);
    chk("R7 no char", got_cnt, n0);
    chk("R11 data held", rx_data, prev);

    // R8 single disturbed sample per bit
    n0 = got_cnt; send_frame(9'h03C, 8, 0, 0, 1, 2'b00, 9'h0FF);
    expect_char("R8 majority", n0, 8'h3C, 0, 0, 0);

    // R9 loopback: 9 bits, no parity, rx_pin ignored (held low)
    set_cfg(2'd1, 1, 0, 1, 0);
    loop_en = 1'b1; wait_clks(8);
    rx_pin = 1'b0; to_loop = 1'b1;
    n0 = got_cnt; send_frame(9'h1A7, 9, 0, 0, 2, 2'b00, 9'h0);
    expect_char("R9 loopback", n0, 8'hA7, 1, 0, 0);
    n0 = got_cnt; wait_clks(10 * BITC);
    chk("R9 pin ignored", got_cnt, n0);
    rx_pin = 1'b1; wait_clks(8);
    loop_en = 1'b0; to_loop = 1'b0; wait_clks(8);

    // R10 attention filter
    set_cfg(2'd2, 0, 0, 0, 1);
    n0 = got_cnt; prev = rx_data;
    send_frame(9'h042, 9, 0, 0, 1, 2'b00, 9'h0);
    chk("R10 dropped count", got_cnt, n0);
    chk("R10 R11 data held", rx_data, prev);
    n0 = got_cnt; send_frame(9'h155, 9, 0, 0, 1, 2'b00, 9'h0);
    expect_char("R10 address", n0, 8'h55, 1, 0, 0);

    // random mix of shapes (R2 R5 R6 R10)
    for (int t = 0; t < 60; t++) begin
      int nb, ns;
      bit pe, po, ts, at, badp, drop;
      bit [1:0] bad;
      logic [8:0] v;
      logic [1:0] dl;
      dl = 2'($urandom % 3);
      nb = 7 + int'(dl);
      pe = 1'($urandom % 2); po = 1'($urandom % 2);
      ts = 1'($urandom % 2); at = 1'($urandom % 2);
      v  = 9'($urandom % 512);
      badp = (($urandom % 8) == 0);
      bad = (($urandom % 8) == 0) ? 2'($urandom % 4) : 2'b00;
      ns = ts ? 2 : 1;
      if (!ts) bad[1] = 1'b0;
      set_cfg(dl, pe, po, ts, at);
      n0 = got_cnt; prev = rx_data;
      drop = at && (nb == 9) && !v[8];
      send_frame(v, nb, pe && nb != 9, par_bit(v, nb, po) ^ badp, ns, bad, 9'h0);
      if (drop) begin
        chk("R10 random drop", got_cnt, n0);
        chk("R10 random held", rx_data, prev);
      end else begin
        expect_char("R2 random", n0, (nb == 7) ? {1'b0, v[6:0]} : v[7:0],
                    (nb == 9) ? v[8] : 1'b0, pe && (nb != 9) && badp, bad != 2'b00);
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule